// File: doc/BRIEF.md
# Bus-Programmed Down-Counting Event Timer

This block is a single-channel event timer reached through an APB slave port. Software programs a reload value and a control word that starts the counter, picks between a repeating period and a free-running count, and masks or passes the interrupt. Once started, the counter loses one step on every clock. When it leaves zero, the timer reloads and latches an interrupt flag. Software clears that flag by reading one of two end-of-interrupt locations.

The programmed value sets the period in periodic mode. Free-running mode ignores it on reload and restarts the count from all ones, which leaves a long window before the next event. The live count can be read at any time. A small global group returns the masked and unmasked flag, clears the flag, and reports a fixed version word. All transfers complete without wait states.

Top module: `apb_dtimer`

## Requirements
- R1: After reset, the control word (offset 0x08), the load value (0x00) and the count (0x04) read as zero, the raw flag (0xA8) reads zero and `irq_o` is low.
- R2: `pready` is always high. A write takes effect on the access phase (`psel` and `penable` high). Offset 0x00 stores the full load value. Offset 0x08 stores bits [2:0] and reads them back with all higher bits zero.
- R3: When control bit 0 (enable) goes from 0 to 1 through a write, the counter takes the load value on that edge. While enabled, a non-zero count decreases by exactly one per clock. Offset 0x04 returns the live count.
- R4: While enable is 0, the count holds its value and reads back unchanged.
- R5: With enable at 1 and control bit 1 at 1 (periodic), a count of zero reloads the load value on the next edge and sets the raw flag. This gives an event every load+1 clocks.
- R6: With enable at 1 and control bit 1 at 0 (free-running), a count of zero reloads 0xFFFFFFFF on the next edge and sets the raw flag.
- R7: The raw flag (bit 0 of 0xA8) sets even when control bit 2 (mask) is 1. `irq_o` and bit 0 of both 0x10 and 0xA0 equal raw AND NOT mask.
- R8: A read of 0x0C or 0xA4 returns the raw flag in bit 0 as it stood before the access, then clears it. If a reload event falls on the same edge, the flag stays set.
- R9: Offset 0xAC returns the version parameter. Every other unmapped offset reads zero. Writes to read-only or unmapped offsets change nothing.
- R10: A load write while the timer runs leaves the current count untouched. The new value is used at the next periodic reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the counter steps once per edge |
| rst_n | input | 1 | Active-low synchronous reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write when high, read when low |
| paddr | input | ADDR_W (8) | APB byte address |
| pwdata | input | DATA_W (32) | APB write data |
| prdata | output | DATA_W (32) | APB read data, valid while a read is selected |
| pready | output | 1 | APB ready, tied high |
| irq_o | output | 1 | Level interrupt, raw flag AND NOT mask |

## Verification
The assertions assume that the bus never issues an access phase without a setup phase before it. They also assume that only this port changes the control word and the load value, so the counter's one-step, hold and reload properties can be stated purely from registered state. The stimulus always drives a full two-phase APB transfer from tasks. Its random load values stay small so that wraps, reloads and end-of-interrupt reads collide often, and it mixes in writes to read-only and unmapped offsets that the decoder must ignore.

// File: rtl/dtimer_pkg.sv
package dtimer_pkg;

    // Byte offsets decoded by the register port
    localparam logic [7:0] OFF_LOAD   = 8'h00;
    localparam logic [7:0] OFF_COUNT  = 8'h04;
    localparam logic [7:0] OFF_CTRL   = 8'h08;
    localparam logic [7:0] OFF_ACK    = 8'h0C;
    localparam logic [7:0] OFF_STAT   = 8'h10;
    localparam logic [7:0] OFF_GSTAT  = 8'hA0;
    localparam logic [7:0] OFF_GACK   = 8'hA4;
    localparam logic [7:0] OFF_GRAW   = 8'hA8;
    localparam logic [7:0] OFF_VER    = 8'hAC;

    localparam int CTRL_W = 3;

    // Control word: bit2 mask, bit1 periodic, bit0 enable
    typedef struct packed {
        logic mask;
        logic periodic;
        logic run;
    } ctrl_t;

    typedef enum logic [3:0] {
        RS_NONE,
        RS_LOAD,
        RS_COUNT,
        RS_CTRL,
        RS_ACK,
        RS_STAT,
        RS_GSTAT,
        RS_GACK,
        RS_GRAW,
        RS_VER
    } rsel_e;

endpackage

// File: rtl/dtimer_apb_dec.sv
module dtimer_apb_dec
    import dtimer_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    output logic              wr_load,
    output logic              wr_ctrl,
    output logic              ack_rd,
    output rsel_e             rsel
);

    logic acc_wr;
    logic acc_rd;
    logic rd_sel;

    assign acc_wr = psel && penable && pwrite;
    assign acc_rd = psel && penable && !pwrite;
    assign rd_sel = psel && !pwrite;

    always_comb begin
        wr_load = acc_wr && (paddr == ADDR_W'(OFF_LOAD));
        wr_ctrl = acc_wr && (paddr == ADDR_W'(OFF_CTRL));
        ack_rd  = acc_rd && ((paddr == ADDR_W'(OFF_ACK)) ||
                             (paddr == ADDR_W'(OFF_GACK)));
    end

    always_comb begin
        rsel = RS_NONE;
        if (rd_sel) begin
            if      (paddr == ADDR_W'(OFF_LOAD))  rsel = RS_LOAD;
            else if (paddr == ADDR_W'(OFF_COUNT)) rsel = RS_COUNT;
            else if (paddr == ADDR_W'(OFF_CTRL))  rsel = RS_CTRL;
            else if (paddr == ADDR_W'(OFF_ACK))   rsel = RS_ACK;
            else if (paddr == ADDR_W'(OFF_STAT))  rsel = RS_STAT;
            else if (paddr == ADDR_W'(OFF_GSTAT)) rsel = RS_GSTAT;
            else if (paddr == ADDR_W'(OFF_GACK))  rsel = RS_GACK;
            else if (paddr == ADDR_W'(OFF_GRAW))  rsel = RS_GRAW;
            else if (paddr == ADDR_W'(OFF_VER))   rsel = RS_VER;
        end
    end

endmodule

// File: rtl/dtimer_cfg.sv
module dtimer_cfg
    import dtimer_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_load,
    input  logic             wr_ctrl,
    input  logic [CNT_W-1:0] wdata,
    output ctrl_t            ctrl,
    output logic [CNT_W-1:0] load_val,
    output logic             start
);

    typedef struct packed {
        ctrl_t            ctrl;
        logic [CNT_W-1:0] load;
    } cfg_state_t;

    cfg_state_t st_d, st_q;
    ctrl_t      wr_ctrl_val;

    assign wr_ctrl_val = ctrl_t'(wdata[CTRL_W-1:0]);

    always_comb begin
        st_d = st_q;
        if (wr_load) begin
            st_d.load = wdata;
        end
        if (wr_ctrl) begin
            st_d.ctrl = wr_ctrl_val;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // Start pulse: enable going from 0 to 1 through a control write
    assign start    = wr_ctrl && wr_ctrl_val.run && !st_q.ctrl.run;
    assign ctrl     = st_q.ctrl;
    assign load_val = st_q.load;

endmodule

// File: rtl/dtimer_counter.sv
module dtimer_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             periodic,
    input  logic             start,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] count,
    output logic             wrap
);

    localparam logic [CNT_W-1:0] FREE_TOP = '1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;
    logic       at_zero;

    assign at_zero = (st_q.cnt == '0);

    always_comb begin
        st_d = st_q;
        wrap = 1'b0;
        if (start) begin
            st_d.cnt = load_val;
        end else if (run) begin
            if (at_zero) begin
                wrap     = 1'b1;
                st_d.cnt = periodic ? load_val : FREE_TOP;
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count = st_q.cnt;

endmodule

// File: rtl/dtimer_irq.sv
module dtimer_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic wrap,
    input  logic ack,
    input  logic mask,
    output logic raw,
    output logic masked
);

    typedef struct packed {
        logic flag;
    } irq_state_t;

    irq_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // A new event on the same edge outranks the clear
        if (wrap) begin
            st_d.flag = 1'b1;
        end else if (ack) begin
            st_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign raw    = st_q.flag;
    assign masked = st_q.flag && !mask;

endmodule

// File: rtl/apb_dtimer.sv
module apb_dtimer
    import dtimer_pkg::*;
#(
    parameter int          ADDR_W  = 8,
    parameter int          DATA_W  = 32,
    parameter int          CNT_W   = 32,
    parameter logic [31:0] VERSION = 32'h0002_0105
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    output logic [DATA_W-1:0] prdata,
    output logic              pready,
    output logic              irq_o
);

    logic             wr_load;
    logic             wr_ctrl;
    logic             ack_rd;
    rsel_e            rsel;
    ctrl_t            ctrl;
    logic [CNT_W-1:0] load_val;
    logic [CNT_W-1:0] count;
    logic             start;
    logic             wrap;
    logic             raw_flag;
    logic             masked_flag;
    logic             ctrl_run;
    logic             ctrl_periodic;
    logic             ctrl_mask;

    dtimer_apb_dec #(.ADDR_W(ADDR_W)) u_dec (
        .psel    (psel),
        .penable (penable),
        .pwrite  (pwrite),
        .paddr   (paddr),
        .wr_load (wr_load),
        .wr_ctrl (wr_ctrl),
        .ack_rd  (ack_rd),
        .rsel    (rsel)
    );

    dtimer_cfg #(.CNT_W(CNT_W)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_load  (wr_load),
        .wr_ctrl  (wr_ctrl),
        .wdata    (pwdata[CNT_W-1:0]),
        .ctrl     (ctrl),
        .load_val (load_val),
        .start    (start)
    );

    assign ctrl_run      = ctrl.run;
    assign ctrl_periodic = ctrl.periodic;
    assign ctrl_mask     = ctrl.mask;

    dtimer_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (ctrl_run),
        .periodic (ctrl_periodic),
        .start    (start),
        .load_val (load_val),
        .count    (count),
        .wrap     (wrap)
    );

    dtimer_irq u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .wrap   (wrap),
        .ack    (ack_rd),
        .mask   (ctrl_mask),
        .raw    (raw_flag),
        .masked (masked_flag)
    );

    always_comb begin
        prdata = '0;
        case (rsel)
            RS_LOAD:  prdata = DATA_W'(load_val);
            RS_COUNT: prdata = DATA_W'(count);
            RS_CTRL:  prdata = DATA_W'(ctrl);
            RS_ACK,
            RS_GACK,
            RS_GRAW:  prdata = DATA_W'(raw_flag);
            RS_STAT,
            RS_GSTAT: prdata = DATA_W'(masked_flag);
            RS_VER:   prdata = DATA_W'(VERSION);
            default:  prdata = '0;
        endcase
    end

    assign pready = 1'b1;
    assign irq_o  = masked_flag;

endmodule

// File: rtl/apb_dtimer_checker.sv
module apb_dtimer_checker #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             irq_o,
    input logic             run,
    input logic             periodic,
    input logic             mask,
    input logic             raw,
    input logic [CNT_W-1:0] count,
    input logic [CNT_W-1:0] load_val
);

    AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run) && ($past(count) != '0)) |-> (count == $past(count) - 1'b1)); // R3

    AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !$past(run)) |-> $stable(count)); // R4

    AST_PERIOD_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        $past(run && periodic && (count == '0)) |-> (count == $past(load_val))); // R5

    AST_FREE_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        $past(run && !periodic && (count == '0)) |-> (&count)); // R6

    AST_RAW_FROM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(raw) |-> $past(run && (count == '0))); // R5

    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (raw && !mask)); // R7

endmodule

bind apb_dtimer apb_dtimer_checker #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .irq_o    (irq_o),
    .run      (ctrl_run),
    .periodic (ctrl_periodic),
    .mask     (ctrl_mask),
    .raw      (raw_flag),
    .count    (count),
    .load_val (load_val)
);

// File: tb/apb_dtimer_test.sv
module apb_dtimer_test;

    localparam logic [31:0] VER = 32'h0002_0105;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        psel = 1'b0;
    logic        penable = 1'b0;
    logic        pwrite = 1'b0;
    logic [7:0]  paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        pready;
    logic        irq_o;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 0;

    // Reference state, advanced once per edge from the requirements
    logic [31:0] m_load = '0;
    logic [2:0]  m_ctrl = '0;
    logic [31:0] m_cnt  = '0;
    logic        m_raw  = 1'b0;

    apb_dtimer #(.VERSION(VER)) uut (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata),
        .prdata(prdata), .pready(pready), .irq_o(irq_o)
    );

    always #2 clk = ~clk;

    always @(posedge clk) begin
        logic acc, wr, rd, wrap;
        logic [2:0]  nctrl;
        logic [31:0] nload, ncnt;
        if (!rst_n) begin
            m_load = '0; m_ctrl = '0; m_cnt = '0; m_raw = 1'b0;
        end else begin
            acc = psel && penable;
            wr = acc && pwrite;
            rd = acc && !pwrite;
            nctrl = m_ctrl; nload = m_load; ncnt = m_cnt; wrap = 1'b0;
            if (wr && paddr == 8'h00) nload = pwdata;
            if (wr && paddr == 8'h08) nctrl = pwdata[2:0];
            if (wr && paddr == 8'h08 && pwdata[0] && !m_ctrl[0]) ncnt = m_load;
            else if (m_ctrl[0]) begin
                if (m_cnt == 0) begin
                    wrap = 1'b1;
                    ncnt = m_ctrl[1] ? m_load : 32'hFFFF_FFFF;
                end else ncnt = m_cnt - 1;
            end
            if (wrap) m_raw = 1'b1;
            else if (rd && (paddr == 8'h0C || paddr == 8'hA4)) m_raw = 1'b0;
            m_ctrl = nctrl; m_load = nload; m_cnt = ncnt;
        end
    end

    function automatic logic [31:0] mdl_rd(input logic [7:0] a);
        case (a)
            8'h00: return m_load;
            8'h04: return m_cnt;
            8'h08: return {29'b0, m_ctrl};
            8'h0C, 8'hA4, 8'hA8: return {31'b0, m_raw};
            8'h10, 8'hA0: return {31'b0, m_raw & ~m_ctrl[2]};
            8'hAC: return VER;
            default: return '0;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
        end
    endtask

    // Interrupt level compared each cycle, away from the edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            #1;
            chk("R7 irq", {31'b0, irq_o}, {31'b0, m_raw & ~m_ctrl[2]});
        end
    end

    task automatic apb_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
        @(negedge clk);
        penable = 1;
        @(negedge clk);
        psel = 0; penable = 0; pwrite = 0;
    endtask

    task automatic apb_rd(input logic [7:0] a, input string tag);
        @(negedge clk);
        psel = 1; penable = 0; pwrite = 0; paddr = a;
        @(negedge clk);
        penable = 1;
        #1;
        chk(tag, prdata, mdl_rd(a));
        chk("R2 pready", {31'b0, pready}, 32'd1);
        @(negedge clk);
        psel = 0; penable = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        #(4 * 150000);
        n_bad++;
        $display("FAIL watchdog: got hung expected finish");
        finish_run();
    end

    localparam logic [7:0] ADDRS [12] = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h10,
        8'hA0, 8'hA4, 8'hA8, 8'hAC, 8'h14, 8'h9C, 8'hF0};

    initial begin
        void'($urandom(32'd29));
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state, literal expectations
        apb_rd(8'h08, "R1 ctrl");
        chk("R1 ctrl lit", prdata, 32'd0);
        apb_rd(8'h00, "R1 load");
        apb_rd(8'h04, "R1 count");
        apb_rd(8'hA8, "R1 raw");
        chk("R1 irq", {31'b0, irq_o}, 32'd0);

        // R2 register storage and readback
        apb_wr(8'h00, 32'hDEAD_BEEF);
        apb_rd(8'h00, "R2 load");
        apb_wr(8'h08, 32'hFFFF_FFF8);
        apb_rd(8'h08, "R2 ctrl upper zero");

        // R9 read-only/unmapped writes ignored, version, unmapped zero
        apb_wr(8'h04, 32'h1234_5678);
        apb_wr(8'hA8, 32'h1);
        apb_wr(8'h40, 32'hFFFF_FFFF);
        apb_rd(8'h04, "R9 count untouched");
        apb_rd(8'hAC, "R9 version");
        chk("R9 version lit", prdata, VER);
        apb_rd(8'h44, "R9 unmapped");

        // R3/R5 periodic, load 5
        apb_wr(8'h00, 32'd5);
        apb_wr(8'h08, 32'b011);
        apb_rd(8'h04, "R3 live count");
        idle(7);
        apb_rd(8'h10, "R5 periodic status");
        apb_rd(8'h0C, "R8 ack returns flag");
        apb_rd(8'hA8, "R8 raw cleared");
        // R10 load change while running
        apb_wr(8'h00, 32'd9);
        apb_rd(8'h04, "R10 count untouched");
        idle(12);
        apb_rd(8'h04, "R10 new period");
        // R4 disable holds
        apb_wr(8'h08, 32'b010);
        idle(5);
        apb_rd(8'h04, "R4 held");
        idle(3);
        apb_rd(8'h04, "R4 still held");

        // R6 free-running, masked R7
        apb_wr(8'h00, 32'd3);
        apb_wr(8'h08, 32'b101);
        idle(6);
        apb_rd(8'h04, "R6 reload all ones");
        apb_rd(8'hA8, "R7 raw while masked");
        apb_rd(8'hA0, "R7 masked global");
        apb_wr(8'h08, 32'b001);
        apb_rd(8'h10, "R7 unmasked status");
        apb_rd(8'hA4, "R8 global ack");
        apb_rd(8'hA0, "R8 cleared global");
        apb_wr(8'h08, 32'b000);

        // R8 ack colliding with a wrap: load 0 periodic wraps every clock
        apb_wr(8'h00, 32'd0);
        apb_wr(8'h08, 32'b011);
        apb_rd(8'h0C, "R8 ack vs wrap");
        apb_rd(8'hA8, "R8 wrap wins");
        apb_wr(8'h08, 32'b000);

        // Random mix
        for (int i = 0; i < 500; i++) begin
            int op;
            op = $urandom % 7;
            case (op)
                0: apb_wr(8'h00, $urandom % 24);
                1: apb_wr(8'h08, $urandom % 8);
                2, 3: apb_rd(ADDRS[$urandom % 12], "R9 random read");
                4: idle($urandom % 30);
                5: apb_wr(ADDRS[1 + ($urandom % 11)] == 8'h08 ? 8'h14 : ADDRS[1 + ($urandom % 11)], $urandom);
                default: apb_rd(($urandom % 2) ? 8'h0C : 8'hA4, "R8 random ack");
            endcase
        end
        idle(2);
        finish_run();
    end

endmodule